// File: doc/BRIEF.md
# Wide Register Access Bridge

The bridge connects a 32-bit host register bus to a bank of 128-bit control and status registers, so that the host can move each wide register as four 32-bit dwords and never see or produce a torn value. On the read side a single read latch holds a full 128-bit snapshot: a read of a register's first dword, or of any dword of a register other than the one held, captures the whole register, and later reads of the remaining dwords of that register are answered from the snapshot. On the write side a single write collector gathers dwords and updates an ordinary wide register only once all four of its dwords have arrived.

Two descriptor-pointer registers per page follow relaxed rules so that software can update them without a lock. They are write-only. A write to their top dword always commits them, with any lower dword the collector does not hold for that pointer filled with zero, and a write to one of their lower dwords is dropped while the collector is busy with another register. A commit is handed to the downstream engines as a one-cycle pulse carrying the page, which pointer, and the 128-bit value. The whole register map repeats in pages of 0x2000 bytes, and each page also holds plain 32-bit registers that are read and written directly.

Top module: `wrb_bridge`

## Requirements
- R1: An ordinary wide register (page offset 16*n, n below NUM_WIDE, dword d at offset 16*n+4*d) is updated only when the collector holds all four of its dwords, in any order; until then reads of it return the old value.
- R2: A write to an ordinary wide register other than the one the collector holds discards the partial data and restarts collection with the new dword alone.
- R3: A read of dword 0 of an ordinary wide register returns its live value and captures all 128 bits into the read latch.
- R4: A read of any dword of an ordinary wide register that is not the one in the latch (a different page counts as different), or while the latch is empty, returns the live dword and captures the whole register into the latch.
- R5: A read of dword 1, 2 or 3 of the register held in the latch returns the latched data, even if that register has been written since.
- R6: Each page holds descriptor pointer 0 at offset 0x830 and pointer 1 at 0xA10. A write to the top dword (0x83C or 0xA1C) always commits: one cycle later dptr_commit pulses with dptr_page, dptr_sel (0 or 1) and dptr_data whose top dword is the written data and whose lower dwords are the ones the collector holds for that same pointer, zero otherwise. The collector is emptied only if it held that pointer, otherwise it keeps its contents.
- R7: A write to dword 0, 1 or 2 of a descriptor pointer while the collector holds data for a different register is discarded and the collector keeps its contents; otherwise the dword is collected.
- R8: Reads of descriptor pointers and of unmapped offsets return zero and leave the read latch unchanged.
- R9: Plain 32-bit registers at page offset 0x400+4*i (i below NUM_NARROW) are written and read directly, without touching the latch or the collector.
- R10: The page is host_addr[PAGE_BITS+12:13]; every page has its own registers, reached at page*0x2000 plus the offset.
- R11: host_rvalid is high exactly one cycle after each host_rd, with host_rdata valid in that cycle; a write is visible to a read issued in a later cycle.
- R12: After reset all registers read zero, the latch and collector are empty, and host_rvalid and dptr_commit are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one cycle per dword |
| host_rd | input | 1 | Host read strobe, one cycle per dword |
| host_addr | input | PAGE_BITS+13 | Host byte address: page and offset within the page |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read data valid, one cycle after host_rd |
| dptr_commit | output | 1 | One-cycle pulse when a descriptor pointer commits |
| dptr_page | output | PAGE_BITS | Page of the committed pointer |
| dptr_sel | output | 1 | Committed pointer: 0 for offset 0x830, 1 for 0xA10 |
| dptr_data | output | 128 | Committed 128-bit pointer value |

## Verification
The assertions watch, on every cycle, the per-access rules that a single cycle can show: the collector is empty after a wide commit, holds one dword after a restart, and is unchanged after a dropped pointer write; a first-dword read fills the latch, a latched read leaves it alone, and pointer or unmapped reads return zero; read data and pointer pulses follow their strobes by exactly one cycle. Only the bench scenarios show the multi-access outcomes: that four dwords written in any order land together, that a restart really loses the earlier dwords, that a latched read returns stale data after a fresh write, that pointer commits zero-fill exactly the missing dwords while a foreign collection survives, and that pages stay independent.

// File: rtl/wrb_pkg.sv
package wrb_pkg;
    typedef enum logic [1:0] {
        RK_NONE   = 2'd0,
        RK_WIDE   = 2'd1,
        RK_NARROW = 2'd2,
        RK_DPTR   = 2'd3
    } reg_kind_e;

    localparam int        PAGE_SHIFT = 13;
    localparam logic [8:0] DPTR0_SLOT = 9'h083;
    localparam logic [8:0] DPTR1_SLOT = 9'h0A1;
    localparam logic [10:0] NARROW_DW_BASE = 11'h100;
endpackage

// File: rtl/wrb_decode.sv
module wrb_decode
    import wrb_pkg::*;
#(
    parameter int PAGE_BITS  = 2,
    parameter int NUM_WIDE   = 4,
    parameter int NUM_NARROW = 2,
    localparam int AW        = PAGE_BITS + PAGE_SHIFT,
    localparam int WIDE_W    = $clog2(NUM_WIDE),
    localparam int NAR_W     = $clog2(NUM_NARROW),
    localparam int IDX_W     = (WIDE_W > NAR_W) ? WIDE_W : NAR_W
) (
    input  logic [AW-1:0]        addr_i,
    output reg_kind_e            kind_o,
    output logic [PAGE_BITS-1:0] page_o,
    output logic [8:0]           slot_o,
    output logic [1:0]           dw_o,
    output logic [IDX_W-1:0]     idx_o
);
    localparam logic [8:0]  WIDE_END = 9'(NUM_WIDE);
    localparam logic [10:0] NAR_CNT  = 11'(NUM_NARROW);

    logic [12:0] off;
    logic [10:0] nar_ofs;

    always_comb begin
        off     = addr_i[PAGE_SHIFT-1:0];
        page_o  = addr_i[AW-1:PAGE_SHIFT];
        slot_o  = off[12:4];
        dw_o    = off[3:2];
        nar_ofs = off[12:2] - NARROW_DW_BASE;
        kind_o  = RK_NONE;
        idx_o   = '0;
        if (slot_o < WIDE_END) begin
            kind_o = RK_WIDE;
            idx_o  = slot_o[IDX_W-1:0];
        end else if (off[12:2] >= NARROW_DW_BASE && nar_ofs < NAR_CNT) begin
            kind_o = RK_NARROW;
            idx_o  = nar_ofs[IDX_W-1:0];
        end else if (slot_o == DPTR0_SLOT) begin
            kind_o = RK_DPTR;
            idx_o  = '0;
        end else if (slot_o == DPTR1_SLOT) begin
            kind_o = RK_DPTR;
            idx_o  = IDX_W'(1);
        end
    end
endmodule

// File: rtl/wrb_collector.sv
module wrb_collector
    import wrb_pkg::*;
#(
    parameter int KEY_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  reg_kind_e        kind_i,
    input  logic [KEY_W-1:0] key_i,
    input  logic [1:0]       dw_i,
    input  logic [31:0]      wdata_i,
    output logic             commit_wide_o,
    output logic             commit_dptr_o,
    output logic [127:0]     commit_data_o
);
    typedef struct packed {
        logic [3:0]       mask;
        logic [KEY_W-1:0] key;
        logic [127:0]     data;
    } coll_t;

    coll_t st_d, st_q;
    logic  hit;
    logic [3:0] dw_bit;

    always_comb begin
        st_d          = st_q;
        commit_wide_o = 1'b0;
        commit_dptr_o = 1'b0;
        commit_data_o = '0;
        hit           = (st_q.mask != 4'b0) && (st_q.key == key_i);
        dw_bit        = 4'b0001 << dw_i;
        if (wr_i) begin
            case (kind_i)
                RK_WIDE: begin
                    st_d.key  = key_i;
                    st_d.mask = (hit ? st_q.mask : 4'b0) | dw_bit;
                    st_d.data[{dw_i, 5'b0} +: 32] = wdata_i;
                    if (st_d.mask == 4'hF) begin
                        commit_wide_o = 1'b1;
                        commit_data_o = st_d.data;
                        st_d.mask     = 4'b0;
                    end
                end
                RK_DPTR: begin
                    if (dw_i == 2'd3) begin
                        for (int i = 0; i < 3; i++) begin
                            commit_data_o[i*32 +: 32] =
                                (hit && st_q.mask[i]) ? st_q.data[i*32 +: 32] : 32'b0;
                        end
                        commit_data_o[127:96] = wdata_i;
                        commit_dptr_o         = 1'b1;
                        if (hit) begin
                            st_d.mask = 4'b0;
                        end
                    end else if (st_q.mask == 4'b0 || hit) begin
                        st_d.key  = key_i;
                        st_d.mask = st_q.mask | dw_bit;
                        st_d.data[{dw_i, 5'b0} +: 32] = wdata_i;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R1: a full commit leaves the collector empty
    p_commit_empties_r1: assert property (@(posedge clk) disable iff (!rst_n)
        commit_wide_o |=> (st_q.mask == 4'b0));

    // R2: a write to another ordinary register restarts with one dword held
    p_restart_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && kind_i == RK_WIDE && st_q.mask != 4'b0 && st_q.key != key_i)
        |=> ($countones(st_q.mask) == 1));

    // R7: a lower pointer dword is dropped while another register is held
    p_discard_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && kind_i == RK_DPTR && dw_i != 2'd3 && st_q.mask != 4'b0 && st_q.key != key_i)
        |=> ($stable(st_q.mask) && $stable(st_q.key) && $stable(st_q.data)));

    // R6: a pointer top write for a foreign register leaves the collection intact
    p_foreign_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && kind_i == RK_DPTR && dw_i == 2'd3 && st_q.key != key_i)
        |=> ($stable(st_q.mask) && $stable(st_q.data)));
endmodule

// File: rtl/wrb_read_latch.sv
module wrb_read_latch
    import wrb_pkg::*;
#(
    parameter int KEY_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_i,
    input  reg_kind_e        kind_i,
    input  logic [KEY_W-1:0] key_i,
    input  logic [1:0]       dw_i,
    input  logic [127:0]     live_wide_i,
    input  logic [31:0]      live_narrow_i,
    output logic [31:0]      rdata_o,
    output logic             rvalid_o
);
    typedef struct packed {
        logic             valid;
        logic [KEY_W-1:0] key;
        logic [127:0]     data;
        logic [31:0]      rdata;
        logic             rvalid;
    } latch_t;

    latch_t st_d, st_q;
    logic   refresh;

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = rd_i;
        refresh     = (dw_i == 2'd0) || !st_q.valid || (st_q.key != key_i);
        if (rd_i) begin
            case (kind_i)
                RK_WIDE: begin
                    if (refresh) begin
                        st_d.valid = 1'b1;
                        st_d.key   = key_i;
                        st_d.data  = live_wide_i;
                        st_d.rdata = live_wide_i[{dw_i, 5'b0} +: 32];
                    end else begin
                        st_d.rdata = st_q.data[{dw_i, 5'b0} +: 32];
                    end
                end
                RK_NARROW: st_d.rdata = live_narrow_i;
                default:   st_d.rdata = 32'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata_o  = st_q.rdata;
    assign rvalid_o = st_q.rvalid;

    // R3: a first-dword read captures the whole live register
    p_dw0_snapshot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && kind_i == RK_WIDE && dw_i == 2'd0)
        |=> (st_q.valid && st_q.key == $past(key_i) && st_q.data == $past(live_wide_i)));

    // R5: a read of a higher dword of the latched register keeps the snapshot
    p_latched_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && kind_i == RK_WIDE && dw_i != 2'd0 && st_q.valid && st_q.key == key_i)
        |=> $stable(st_q.data));

    // R8: pointer and unmapped reads give zero and leave the latch alone
    p_zero_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && (kind_i == RK_DPTR || kind_i == RK_NONE))
        |=> (rdata_o == 32'b0 && $stable(st_q.key) && $stable(st_q.valid) && $stable(st_q.data)));

    // R11: read data follows the strobe by exactly one cycle
    p_rvalid_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid_o == $past(rd_i));
endmodule

// File: rtl/wrb_bridge.sv
module wrb_bridge
    import wrb_pkg::*;
#(
    parameter int PAGE_BITS  = 2,
    parameter int NUM_WIDE   = 4,
    parameter int NUM_NARROW = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            host_wr,
    input  logic                            host_rd,
    input  logic [PAGE_BITS+PAGE_SHIFT-1:0] host_addr,
    input  logic [31:0]                     host_wdata,
    output logic [31:0]                     host_rdata,
    output logic                            host_rvalid,
    output logic                            dptr_commit,
    output logic [PAGE_BITS-1:0]            dptr_page,
    output logic                            dptr_sel,
    output logic [127:0]                    dptr_data
);
    localparam int NUM_PAGES = 1 << PAGE_BITS;
    localparam int WIDE_W    = $clog2(NUM_WIDE);
    localparam int NAR_W     = $clog2(NUM_NARROW);
    localparam int IDX_W     = (WIDE_W > NAR_W) ? WIDE_W : NAR_W;
    localparam int KEY_W     = PAGE_BITS + 9;
    localparam int WIDE_TOT  = NUM_PAGES * NUM_WIDE;
    localparam int NAR_TOT   = NUM_PAGES * NUM_NARROW;

    typedef struct packed {
        logic [WIDE_TOT-1:0][127:0] wide;
        logic [NAR_TOT-1:0][31:0]   narrow;
        logic                       dptr_commit;
        logic [PAGE_BITS-1:0]       dptr_page;
        logic                       dptr_sel;
        logic [127:0]               dptr_data;
    } bank_t;

    bank_t st_d, st_q;

    reg_kind_e            kind;
    logic [PAGE_BITS-1:0] page;
    logic [8:0]           slot;
    logic [1:0]           dw;
    logic [IDX_W-1:0]     idx;
    logic [KEY_W-1:0]     key;
    logic [PAGE_BITS+WIDE_W-1:0] wide_at;
    logic [PAGE_BITS+NAR_W-1:0]  nar_at;
    logic [127:0]         live_wide;
    logic [31:0]          live_narrow;
    logic                 commit_wide, commit_dptr;
    logic [127:0]         commit_data;

    wrb_decode #(
        .PAGE_BITS (PAGE_BITS),
        .NUM_WIDE  (NUM_WIDE),
        .NUM_NARROW(NUM_NARROW)
    ) u_decode (
        .addr_i(host_addr),
        .kind_o(kind),
        .page_o(page),
        .slot_o(slot),
        .dw_o  (dw),
        .idx_o (idx)
    );

    assign key     = {page, slot};
    assign wide_at = {page, idx[WIDE_W-1:0]};
    assign nar_at  = {page, idx[NAR_W-1:0]};

    always_comb begin
        live_wide   = (kind == RK_WIDE)   ? st_q.wide[wide_at]  : 128'b0;
        live_narrow = (kind == RK_NARROW) ? st_q.narrow[nar_at] : 32'b0;
    end

    wrb_collector #(.KEY_W(KEY_W)) u_collector (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_i         (host_wr),
        .kind_i       (kind),
        .key_i        (key),
        .dw_i         (dw),
        .wdata_i      (host_wdata),
        .commit_wide_o(commit_wide),
        .commit_dptr_o(commit_dptr),
        .commit_data_o(commit_data)
    );

    wrb_read_latch #(.KEY_W(KEY_W)) u_latch (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_i         (host_rd),
        .kind_i       (kind),
        .key_i        (key),
        .dw_i         (dw),
        .live_wide_i  (live_wide),
        .live_narrow_i(live_narrow),
        .rdata_o      (host_rdata),
        .rvalid_o     (host_rvalid)
    );

    always_comb begin
        st_d             = st_q;
        st_d.dptr_commit = 1'b0;
        if (commit_wide) begin
            st_d.wide[wide_at] = commit_data;
        end
        if (commit_dptr) begin
            st_d.dptr_commit = 1'b1;
            st_d.dptr_page   = page;
            st_d.dptr_sel    = idx[0];
            st_d.dptr_data   = commit_data;
        end
        if (host_wr && kind == RK_NARROW) begin
            st_d.narrow[nar_at] = host_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dptr_commit = st_q.dptr_commit;
    assign dptr_page   = st_q.dptr_page;
    assign dptr_sel    = st_q.dptr_sel;
    assign dptr_data   = st_q.dptr_data;

    // R6: a pointer top-dword write always yields a pulse for that page and pointer
    p_dptr_top_commits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && kind == RK_DPTR && dw == 2'd3)
        |=> (dptr_commit && dptr_page == $past(page) && dptr_sel == $past(idx[0])
             && dptr_data[127:96] == $past(host_wdata)));

    // R6: no pointer pulse without a write in the cycle before
    p_dptr_needs_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dptr_commit |-> $past(host_wr));

    // R9: a plain register write lands on the addressed register
    p_narrow_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && kind == RK_NARROW)
        |=> (st_q.narrow[$past(nar_at)] == $past(host_wdata)));

    // R1: no wide register changes without a full collection
    p_wide_only_on_commit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr && kind == RK_WIDE) |=> $stable(st_q.wide));
endmodule

// File: tb/test_wrb_bridge.sv
module test_wrb_bridge;
    localparam int PB = 2;
    localparam int AW = PB + 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_wr = 1'b0;
    logic          host_rd = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [31:0]   host_wdata = '0;
    logic [31:0]   host_rdata;
    logic          host_rvalid;
    logic          dptr_commit;
    logic [PB-1:0] dptr_page;
    logic          dptr_sel;
    logic [127:0]  dptr_data;

    always #4 clk = ~clk;

    wrb_bridge #(.PAGE_BITS(PB), .NUM_WIDE(4), .NUM_NARROW(2)) i_wrb_bridge (
        .clk(clk), .rst_n(rst_n),
        .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
        .dptr_commit(dptr_commit), .dptr_page(dptr_page), .dptr_sel(dptr_sel),
        .dptr_data(dptr_data)
    );

    int checks = 0;
    int errors = 0;
    logic [31:0]     rd_exp_q[$];
    string           rd_tag_q[$];
    logic [PB+128:0] dp_exp_q[$];
    string           dp_tag_q[$];

    function automatic logic [AW-1:0] at(int page, int off);
        return AW'(page * 32'h2000 + off);
    endfunction

    function automatic logic [PB+128:0] dp(int page, bit sel, logic [127:0] d);
        return {PB'(page), sel, d};
    endfunction

    task automatic check(bit ok, string tag, logic [131:0] act, logic [131:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(int page, int off, logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = at(page, off); host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic wr4(int page, int base, logic [31:0] d0, logic [31:0] d1,
                       logic [31:0] d2, logic [31:0] d3);
        wr(page, base, d0); wr(page, base + 4, d1);
        wr(page, base + 8, d2); wr(page, base + 12, d3);
    endtask

    task automatic rd(int page, int off, logic [31:0] exp, string tag);
        rd_exp_q.push_back(exp);
        rd_tag_q.push_back(tag);
        @(negedge clk);
        host_rd = 1'b1; host_addr = at(page, off);
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic expect_dp(int page, bit sel, logic [127:0] d, string tag);
        dp_exp_q.push_back(dp(page, sel, d));
        dp_tag_q.push_back(tag);
    endtask

    // Monitor: pops one expected item per output event
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && host_rvalid) begin
                if (rd_exp_q.size() == 0) begin
                    check(1'b0, "R11 unexpected rvalid", 132'(host_rdata), 132'(0));
                end else begin
                    logic [31:0] e;
                    string t;
                    e = rd_exp_q.pop_front();
                    t = rd_tag_q.pop_front();
                    check(host_rdata == e, t, 132'(host_rdata), 132'(e));
                end
            end
            if (rst_n && dptr_commit) begin
                logic [PB+128:0] got;
                got = {dptr_page, dptr_sel, dptr_data};
                if (dp_exp_q.size() == 0) begin
                    check(1'b0, "R6 unexpected dptr_commit", 132'(got), 132'(0));
                end else begin
                    logic [PB+128:0] e;
                    string t;
                    e = dp_exp_q.pop_front();
                    t = dp_tag_q.pop_front();
                    check(got == e, t, 132'(got), 132'(e));
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog expired", 132'(0), 132'(1));
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(host_rvalid == 1'b0 && dptr_commit == 1'b0, "R12 outputs in reset",
              132'({host_rvalid, dptr_commit}), 132'(0));
        rst_n = 1'b1;
        @(negedge clk);

        // R12: registers start at zero
        rd(0, 'h000, 32'h0, "R12 wide reset");
        rd(0, 'h400, 32'h0, "R12 narrow reset");

        // R1: out-of-order partial writes do not commit
        wr(0, 'h01C, 32'hA000_0003);
        wr(0, 'h014, 32'hA000_0001);
        wr(0, 'h010, 32'hA000_0000);
        rd(0, 'h010, 32'h0, "R1 no commit on three dwords");
        wr(0, 'h018, 32'hA000_0002);
        rd(0, 'h010, 32'hA000_0000, "R1 dword0 after fourth write");
        rd(0, 'h014, 32'hA000_0001, "R1 dword1");
        rd(0, 'h018, 32'hA000_0002, "R1 dword2");
        rd(0, 'h01C, 32'hA000_0003, "R1 dword3");

        // R5: latched reads stay stale; R3: dword0 refreshes
        wr4(0, 'h020, 32'hC000_0000, 32'hC000_0001, 32'hC000_0002, 32'hC000_0003);
        wr4(0, 'h010, 32'hB000_0000, 32'hB000_0001, 32'hB000_0002, 32'hB000_0003);
        rd(0, 'h018, 32'hA000_0002, "R5 latched after rewrite");
        rd(0, 'h010, 32'hB000_0000, "R3 dword0 refresh");
        rd(0, 'h01C, 32'hB000_0003, "R3 snapshot dword3");

        // R4: a read of another register refreshes the whole latch
        rd(0, 'h028, 32'hC000_0002, "R4 other register refresh");
        wr4(0, 'h020, 32'hD000_0000, 32'hD000_0001, 32'hD000_0002, 32'hD000_0003);
        rd(0, 'h024, 32'hC000_0001, "R4 whole register captured");
        rd(0, 'h020, 32'hD000_0000, "R3 refresh after rewrite");

        // R2: switching register discards partial data
        wr(0, 'h000, 32'hE000_0000);
        wr(0, 'h004, 32'hE000_0001);
        wr(0, 'h030, 32'hF000_0000);
        wr(0, 'h008, 32'hE000_0002);
        wr(0, 'h00C, 32'hE000_0003);
        rd(0, 'h000, 32'h0, "R2 no commit after restarts");
        wr(0, 'h000, 32'h6000_0000);
        wr(0, 'h400, 32'h1111_0000);  // R9: plain write in the middle
        wr(0, 'h004, 32'h6000_0001);
        rd(0, 'h000, 32'h6000_0000, "R2 commit dword0");
        rd(0, 'h004, 32'h6000_0001, "R2 commit dword1");
        rd(0, 'h008, 32'hE000_0002, "R2 kept dword2");
        rd(0, 'h00C, 32'hE000_0003, "R2 kept dword3");
        rd(0, 'h030, 32'h0, "R2 discarded register untouched");

        // R9: plain registers
        rd(0, 'h400, 32'h1111_0000, "R9 plain read");
        wr(0, 'h404, 32'h2222_0001);
        rd(0, 'h404, 32'h2222_0001, "R9 second plain register");
        rd(1, 'h400, 32'h0, "R10 plain per page");

        // R10: pages are independent
        wr4(1, 'h000, 32'h5000_0000, 32'h5000_0001, 32'h5000_0002, 32'h5000_0003);
        rd(1, 'h008, 32'h5000_0002, "R10 page1 register");
        rd(0, 'h008, 32'hE000_0002, "R10 page0 unaffected");
        wr(3, 'h404, 32'h3333_0003);
        rd(3, 'h404, 32'h3333_0003, "R10 page3 plain");
        rd(0, 'h404, 32'h2222_0001, "R10 page0 plain unaffected");

        // R6: pointer commits with zero fill
        expect_dp(2, 1'b0, {32'h9000_0003, 32'h0, 32'h9000_0001, 32'h9000_0000},
                  "R6 pointer0 page2 partial fill");
        wr(2, 'h830, 32'h9000_0000);
        wr(2, 'h834, 32'h9000_0001);
        wr(2, 'h83C, 32'h9000_0003);
        expect_dp(1, 1'b1, {32'h7700_0003, 96'h0}, "R6 pointer1 page1 top only");
        wr(1, 'hA1C, 32'h7700_0003);

        // R6: top write while another register is collected keeps that collection
        wr(0, 'h010, 32'h4000_0000);
        expect_dp(0, 1'b1, {32'h8800_0003, 96'h0}, "R6 foreign collection zero fill");
        wr(0, 'hA1C, 32'h8800_0003);
        wr(0, 'h014, 32'h4000_0001);
        wr(0, 'h018, 32'h4000_0002);
        wr(0, 'h01C, 32'h4000_0003);
        rd(0, 'h010, 32'h4000_0000, "R6 collection survived pointer commit");

        // R7: lower pointer dword dropped while another register is held
        wr(0, 'h000, 32'h3000_0000);
        wr(0, 'h830, 32'hEEEE_0000);
        wr(0, 'h004, 32'h3000_0001);
        wr(0, 'h008, 32'h3000_0002);
        wr(0, 'h00C, 32'h3000_0003);
        expect_dp(0, 1'b0, {32'hCC00_0003, 96'h0}, "R7 dropped dword not in commit");
        wr(0, 'h83C, 32'hCC00_0003);
        rd(0, 'h000, 32'h3000_0000, "R7 ordinary commit intact dword0");
        rd(0, 'h00C, 32'h3000_0003, "R7 ordinary commit intact dword3");

        // R8: pointer and unmapped reads give zero, latch untouched
        rd(0, 'h010, 32'h4000_0000, "R8 latch setup");
        wr4(0, 'h010, 32'h2000_0000, 32'h2000_0001, 32'h2000_0002, 32'h2000_0003);
        rd(0, 'h830, 32'h0, "R8 pointer0 read zero");
        rd(0, 'hA1C, 32'h0, "R8 pointer1 read zero");
        rd(0, 'h200, 32'h0, "R8 unmapped read zero");
        rd(0, 'h014, 32'h4000_0001, "R8 latch unchanged");

        repeat (4) @(negedge clk);
        check(rd_exp_q.size() == 0, "R11 every read answered",
              132'(rd_exp_q.size()), 132'(0));
        check(dp_exp_q.size() == 0, "R6 every pointer commit seen",
              132'(dp_exp_q.size()), 132'(0));
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule